// File: doc/BRIEF.md
# Rotated Framebuffer DMA Parameter Calculator

This unit turns the geometry of a framebuffer into the six values that a DMA source with two index levels needs in order to read the image in a rotated or mirrored order. The inputs are a base byte address, the visible width and height in pixels, an optional virtual line width, horizontal and vertical scale factors, an element size code, a rotation code and a mirror flag. When a start pulse is accepted, the unit captures these inputs and produces the following values: the first and last byte addresses touched (top and bottom), the signed byte jump between two elements in a burst (element index), the signed jump from the end of one burst to the start of the next (frame index), and the element and frame counts.

Every value comes from one addressing rule. Pixel (x, y) sits at `base + (y*vline*yscale + x*xscale)*esize`. A step from pixel A to pixel B is `addr(B) - addr(A) - esize + 1`. Each rotation and mirror setting selects which pixels act as the corners and which pairs of pixels define the two steps. The unit evaluates one pixel per cycle through a single shared multiplier path, then forms the outputs. It raises `done_o` for one cycle when the outputs are valid, and raises `err_o` when the settings are rejected.

Top module: `fbr_dma_calc`

## Requirements
- R1: After reset, `done_o` and `err_o` are low and every numeric output is zero.
- R2: Element size code 0 means 1 byte, code 1 means 2 bytes, code 2 means 4 bytes. Code 3 is rejected as an error.
- R3: Pixel (x,y) has byte address base + (y*vline*yscale + x*xscale)*esize. A virtual width of 0 means the visible width, and a scale of 0 means 1. Top and bottom are the addresses of the corner pixels selected by R5/R7. Addresses wrap modulo 2^ADDR_W.
- R4: A start is rejected as an error when the width or the height is zero, or when a nonzero virtual width is below the width.
- R5: Rotation codes 0,1,2,3 mean 0, 90, 180 and 270 degrees. Codes 4 to 7 are errors. At 90 and 270 degrees the element count is the height and the frame count is the width; at 0 and 180 degrees it is the other way round.
- R6: The element index is the step between two consecutive pixels of a burst. The frame index is the step from the last pixel of one burst to the first pixel of the next. A step from A to B is addr(B)-addr(A)-esize+1, given as 32-bit two's complement.
- R7: Corners and step pixels per rotation/mirror, with W=w-1 and H=h-1, listed as (top; bottom; element step; frame step): 0/no mirror (0,0);(W,H);(0,0)>(1,0);(W,0)>(0,1). 0/mirror (W,0);(0,H);(1,0)>(0,0);(0,0)>(W,1). 90/no (0,H);(W,0);(0,1)>(0,0);(0,0)>(1,H). 90/mirror (W,H);(0,0);(0,1)>(0,0);(1,0)>(0,H). 180/no (W,H);(0,0);(1,0)>(0,0);(0,1)>(W,0). 180/mirror (0,H);(W,0);(0,0)>(1,0);(W,1)>(0,0). 270/no (W,0);(0,H);(0,0)>(0,1);(1,H)>(0,0). 270/mirror (0,0);(W,H);(0,0)>(0,1);(0,H)>(1,0).
- R8: For an accepted valid start, `done_o` is high for exactly one cycle, 7 clock edges after the edge that samples the start. A rejected start pulses `done_o` with `err_o` high one edge after the start. `err_o` then holds until the next accepted start.
- R9: A start that arrives while a calculation is in progress is ignored, and the result of the calculation already running is not affected.
- R10: The numeric outputs change only together with a `done_o` pulse that has no error. A rejected start leaves them at their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; samples all configuration inputs |
| base_i | input | ADDR_W | Framebuffer base byte address |
| width_i | input | DIM_W | Visible width in pixels |
| height_i | input | DIM_W | Visible height in pixels |
| vwidth_i | input | DIM_W | Virtual line width in pixels, 0 = visible width |
| xscale_i | input | SCL_W | Horizontal pixel stride, 0 = 1 |
| yscale_i | input | SCL_W | Vertical line stride, 0 = 1 |
| esize_i | input | 2 | Element size code |
| rot_i | input | 3 | Rotation code |
| mirror_i | input | 1 | Mirror enable |
| done_o | output | 1 | One-cycle result pulse |
| err_o | output | 1 | Last start was rejected |
| top_o | output | ADDR_W | First byte address |
| bot_o | output | ADDR_W | Last byte address |
| elem_idx_o | output | 32 | Element index, two's complement |
| frame_idx_o | output | 32 | Frame index, two's complement |
| elem_cnt_o | output | DIM_W | Elements per frame |
| frame_cnt_o | output | DIM_W | Frames per transfer |

## Verification
A valid result is due on the seventh rising edge after the edge that samples start. A rejected start answers on the very next edge. The bench drives start on a falling edge. It confirms that done is still low at the falling edge just before the result is due, then reads every output at the following falling edge and confirms one falling edge later that done has dropped. Tests of a start during a running calculation, of input changes after done and of rejected starts are all sampled on that same falling-edge grid, so each result is checked in the cycle it is due.

// File: rtl/fbr_pkg.sv
package fbr_pkg;
   // coordinate selector: zero, one, or last (w-1 / h-1)
   typedef enum logic [1:0] {
      CS_Z = 2'd0,
      CS_O = 2'd1,
      CS_M = 2'd2
   } coord_sel_e;

   typedef struct packed {
      coord_sel_e cx;
      coord_sel_e cy;
   } pt_sel_t;

   localparam int NPT = 6;   // top, bottom, elemA, elemB, frameA, frameB
endpackage

// File: rtl/fbr_point_map.sv
module fbr_point_map
   import fbr_pkg::*;
(
   input  logic [1:0] rot_i,
   input  logic       mir_i,
   input  logic [2:0] idx_i,
   output pt_sel_t    sel_o
);
   function automatic pt_sel_t mk(input coord_sel_e x, input coord_sel_e y);
      mk.cx = x;
      mk.cy = y;
   endfunction

   pt_sel_t tab [8];

   always_comb begin
      for (int i = 0; i < 8; i++) tab[i] = mk(CS_Z, CS_Z);
      unique case ({rot_i, mir_i})
         3'b000: begin tab[0]=mk(CS_Z,CS_Z); tab[1]=mk(CS_M,CS_M); tab[2]=mk(CS_Z,CS_Z);
                       tab[3]=mk(CS_O,CS_Z); tab[4]=mk(CS_M,CS_Z); tab[5]=mk(CS_Z,CS_O); end
         3'b001: begin tab[0]=mk(CS_M,CS_Z); tab[1]=mk(CS_Z,CS_M); tab[2]=mk(CS_O,CS_Z);
                       tab[3]=mk(CS_Z,CS_Z); tab[4]=mk(CS_Z,CS_Z); tab[5]=mk(CS_M,CS_O); end
         3'b010: begin tab[0]=mk(CS_Z,CS_M); tab[1]=mk(CS_M,CS_Z); tab[2]=mk(CS_Z,CS_O);
                       tab[3]=mk(CS_Z,CS_Z); tab[4]=mk(CS_Z,CS_Z); tab[5]=mk(CS_O,CS_M); end
         3'b011: begin tab[0]=mk(CS_M,CS_M); tab[1]=mk(CS_Z,CS_Z); tab[2]=mk(CS_Z,CS_O);
                       tab[3]=mk(CS_Z,CS_Z); tab[4]=mk(CS_O,CS_Z); tab[5]=mk(CS_Z,CS_M); end
         3'b100: begin tab[0]=mk(CS_M,CS_M); tab[1]=mk(CS_Z,CS_Z); tab[2]=mk(CS_O,CS_Z);
                       tab[3]=mk(CS_Z,CS_Z); tab[4]=mk(CS_Z,CS_O); tab[5]=mk(CS_M,CS_Z); end
         3'b101: begin tab[0]=mk(CS_Z,CS_M); tab[1]=mk(CS_M,CS_Z); tab[2]=mk(CS_Z,CS_Z);
                       tab[3]=mk(CS_O,CS_Z); tab[4]=mk(CS_M,CS_O); tab[5]=mk(CS_Z,CS_Z); end
         3'b110: begin tab[0]=mk(CS_M,CS_Z); tab[1]=mk(CS_Z,CS_M); tab[2]=mk(CS_Z,CS_Z);
                       tab[3]=mk(CS_Z,CS_O); tab[4]=mk(CS_O,CS_M); tab[5]=mk(CS_Z,CS_Z); end
         default: begin tab[0]=mk(CS_Z,CS_Z); tab[1]=mk(CS_M,CS_M); tab[2]=mk(CS_Z,CS_Z);
                       tab[3]=mk(CS_Z,CS_O); tab[4]=mk(CS_Z,CS_M); tab[5]=mk(CS_O,CS_Z); end
      endcase
      sel_o = tab[idx_i];
   end
endmodule

// File: rtl/fbr_pix_off.sv
module fbr_pix_off
   import fbr_pkg::*;
#(
   parameter int DIM_W = 12,
   parameter int SCL_W = 4,
   localparam int PIT_W = DIM_W + SCL_W,
   localparam int OFF_W = 2 * DIM_W + SCL_W + 1
) (
   input  pt_sel_t            sel_i,
   input  logic [DIM_W-1:0]   wm1_i,
   input  logic [DIM_W-1:0]   hm1_i,
   input  logic [SCL_W-1:0]   xstep_i,
   input  logic [PIT_W-1:0]   pitch_i,
   output logic [OFF_W-1:0]   off_o
);
   logic [DIM_W-1:0] xv, yv;

   always_comb begin
      unique case (sel_i.cx)
         CS_Z:    xv = '0;
         CS_O:    xv = DIM_W'(1);
         default: xv = wm1_i;
      endcase
      unique case (sel_i.cy)
         CS_Z:    yv = '0;
         CS_O:    yv = DIM_W'(1);
         default: yv = hm1_i;
      endcase
      // offset in elements: y * line pitch + x * pixel stride
      off_o = OFF_W'(yv) * OFF_W'(pitch_i) + OFF_W'(xv) * OFF_W'(xstep_i);
   end
endmodule

// File: rtl/fbr_step.sv
module fbr_step #(
   parameter int OFF_W = 29,
   parameter int IDX_W = 32
) (
   input  logic [OFF_W-1:0] from_i,
   input  logic [OFF_W-1:0] to_i,
   input  logic [1:0]       sh_i,
   output logic [IDX_W-1:0] step_o
);
   logic [IDX_W-1:0] diff, bytes;

   always_comb begin
      diff   = IDX_W'(to_i) - IDX_W'(from_i);   // modular, two's complement
      bytes  = diff << sh_i;
      step_o = bytes - (IDX_W'(1) << sh_i) + IDX_W'(1);
   end
endmodule

// File: rtl/fbr_dma_calc.sv
module fbr_dma_calc
   import fbr_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DIM_W  = 12,
   parameter int SCL_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [DIM_W-1:0]  width_i,
   input  logic [DIM_W-1:0]  height_i,
   input  logic [DIM_W-1:0]  vwidth_i,
   input  logic [SCL_W-1:0]  xscale_i,
   input  logic [SCL_W-1:0]  yscale_i,
   input  logic [1:0]        esize_i,
   input  logic [2:0]        rot_i,
   input  logic              mirror_i,
   output logic              done_o,
   output logic              err_o,
   output logic [ADDR_W-1:0] top_o,
   output logic [ADDR_W-1:0] bot_o,
   output logic [31:0]       elem_idx_o,
   output logic [31:0]       frame_idx_o,
   output logic [DIM_W-1:0]  elem_cnt_o,
   output logic [DIM_W-1:0]  frame_cnt_o
);
   localparam int IDX_W = 32;
   localparam int PIT_W = DIM_W + SCL_W;
   localparam int OFF_W = 2 * DIM_W + SCL_W + 1;
   localparam int K_W   = $clog2(NPT + 1);
   localparam logic [K_W-1:0] K_LAST = K_W'(NPT);

   // elaboration checks: byte offset (x4) plus sign must fit the index word
   generate
      if (OFF_W + 3 > IDX_W) begin : g_chk_idx
         $error("fbr_dma_calc: DIM_W/SCL_W too wide for 32-bit indices");
      end
      if (ADDR_W < 8 || ADDR_W > 64) begin : g_chk_addr
         $error("fbr_dma_calc: ADDR_W out of range");
      end
      if (SCL_W < 1) begin : g_chk_scl
         $error("fbr_dma_calc: SCL_W must be at least 1");
      end
   endgenerate

   // ---------------- configuration validation ----------------
   logic cfg_bad;
   always_comb begin
      cfg_bad = (esize_i == 2'd3) || (rot_i > 3'd3) ||
                (width_i == '0) || (height_i == '0) ||
                ((vwidth_i != '0) && (vwidth_i < width_i));
   end

   // ---------------- captured configuration ----------------
   logic [ADDR_W-1:0] base_q;
   logic [DIM_W-1:0]  w_q, h_q, vw_q;
   logic [SCL_W-1:0]  xs_q, ys_q;
   logic [1:0]        sh_q, rot_q;
   logic              mir_q;
   logic              busy_q;
   logic [K_W-1:0]    k_q;
   logic [OFF_W-1:0]  pt_q [NPT];

   logic [PIT_W-1:0]  pitch;
   logic [DIM_W-1:0]  wm1, hm1;
   pt_sel_t           sel;
   logic [OFF_W-1:0]  off_cur;
   logic [IDX_W-1:0]  ei_nxt, fi_nxt;

   assign pitch = PIT_W'(vw_q) * PIT_W'(ys_q);
   assign wm1   = w_q - DIM_W'(1);
   assign hm1   = h_q - DIM_W'(1);

   fbr_point_map u_map (
      .rot_i (rot_q),
      .mir_i (mir_q),
      .idx_i (3'(k_q)),
      .sel_o (sel)
   );

   fbr_pix_off #(.DIM_W(DIM_W), .SCL_W(SCL_W)) u_off (
      .sel_i   (sel),
      .wm1_i   (wm1),
      .hm1_i   (hm1),
      .xstep_i (xs_q),
      .pitch_i (pitch),
      .off_o   (off_cur)
   );

   fbr_step #(.OFF_W(OFF_W), .IDX_W(IDX_W)) u_ei (
      .from_i (pt_q[2]), .to_i (pt_q[3]), .sh_i (sh_q), .step_o (ei_nxt)
   );

   fbr_step #(.OFF_W(OFF_W), .IDX_W(IDX_W)) u_fi (
      .from_i (pt_q[4]), .to_i (pt_q[5]), .sh_i (sh_q), .step_o (fi_nxt)
   );

   // ---------------- sequencer and result registers ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0; w_q <= '0; h_q <= '0; vw_q <= '0;
         xs_q <= '0; ys_q <= '0; sh_q <= '0; rot_q <= '0; mir_q <= 1'b0;
         busy_q <= 1'b0; k_q <= '0;
         for (int i = 0; i < NPT; i++) pt_q[i] <= '0;
         done_o <= 1'b0; err_o <= 1'b0;
         top_o <= '0; bot_o <= '0; elem_idx_o <= '0; frame_idx_o <= '0;
         elem_cnt_o <= '0; frame_cnt_o <= '0;
      end else begin
         done_o <= 1'b0;
         if (!busy_q) begin
            if (start_i) begin
               if (cfg_bad) begin
                  done_o <= 1'b1;
                  err_o  <= 1'b1;
               end else begin
                  err_o  <= 1'b0;
                  busy_q <= 1'b1;
                  k_q    <= '0;
                  base_q <= base_i;
                  w_q    <= width_i;
                  h_q    <= height_i;
                  vw_q   <= (vwidth_i == '0) ? width_i : vwidth_i;
                  xs_q   <= (xscale_i == '0) ? SCL_W'(1) : xscale_i;
                  ys_q   <= (yscale_i == '0) ? SCL_W'(1) : yscale_i;
                  sh_q   <= esize_i;
                  rot_q  <= rot_i[1:0];
                  mir_q  <= mirror_i;
               end
            end
         end else if (k_q != K_LAST) begin
            pt_q[k_q[2:0]] <= off_cur;
            k_q <= k_q + K_W'(1);
         end else begin
            busy_q      <= 1'b0;
            done_o      <= 1'b1;
            top_o       <= base_q + (ADDR_W'(pt_q[0]) << sh_q);
            bot_o       <= base_q + (ADDR_W'(pt_q[1]) << sh_q);
            elem_idx_o  <= ei_nxt;
            frame_idx_o <= fi_nxt;
            elem_cnt_o  <= rot_q[0] ? h_q : w_q;
            frame_cnt_o <= rot_q[0] ? w_q : h_q;
         end
      end
   end
endmodule

// File: rtl/fbr_dma_calc_chk.sv
module fbr_dma_calc_chk #(
   parameter int ADDR_W = 32,
   parameter int DIM_W  = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy_q,
   input logic              done_o,
   input logic              err_o,
   input logic [ADDR_W-1:0] top_o,
   input logic [ADDR_W-1:0] bot_o,
   input logic [31:0]       elem_idx_o,
   input logic [31:0]       frame_idx_o,
   input logic [DIM_W-1:0]  elem_cnt_o,
   input logic [DIM_W-1:0]  frame_cnt_o
);
   a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r8_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_o) |-> done_o);

   a_r9_result_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !err_o) |-> $past(busy_q));

   a_r10_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && !err_o) |-> ($stable(top_o) && $stable(bot_o)));

   a_r10_hold_idx: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && !err_o) |-> ($stable(elem_idx_o) && $stable(frame_idx_o)
                               && $stable(elem_cnt_o) && $stable(frame_cnt_o)));

   a_r4_counts_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !err_o) |-> (elem_cnt_o != '0 && frame_cnt_o != '0));
endmodule

bind fbr_dma_calc fbr_dma_calc_chk #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .busy_q      (busy_q),
   .done_o      (done_o),
   .err_o       (err_o),
   .top_o       (top_o),
   .bot_o       (bot_o),
   .elem_idx_o  (elem_idx_o),
   .frame_idx_o (frame_idx_o),
   .elem_cnt_o  (elem_cnt_o),
   .frame_cnt_o (frame_cnt_o)
);

// File: tb/fbr_dma_calc_bench.sv
module fbr_dma_calc_bench;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] base = '0;
   logic [11:0] wd = '0, ht = '0, vw = '0;
   logic [3:0]  xs = '0, ys = '0;
   logic [1:0]  es = '0;
   logic [2:0]  rot = '0;
   logic        mir = 1'b0;
   logic        done, err;
   logic [31:0] top, bot, ei, fi;
   logic [11:0] en, fn;

   int checks = 0;
   int errors = 0;

   always #(CLK_P/2) clk = ~clk;

   fbr_dma_calc u_fbr_dma_calc (
      .clk(clk), .rst_n(rst_n), .start_i(start), .base_i(base),
      .width_i(wd), .height_i(ht), .vwidth_i(vw), .xscale_i(xs), .yscale_i(ys),
      .esize_i(es), .rot_i(rot), .mirror_i(mir),
      .done_o(done), .err_o(err), .top_o(top), .bot_o(bot),
      .elem_idx_o(ei), .frame_idx_o(fi), .elem_cnt_o(en), .frame_cnt_o(fn)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // expected values, straight from the addressing rule
   logic [31:0] x_top, x_bot, x_ei, x_fi;
   logic [11:0] x_en, x_fn;

   function automatic bit cfg_is_bad();
      return (es == 2'd3) || (rot > 3'd3) || (wd == 0) || (ht == 0) ||
             ((vw != 0) && (vw < wd));
   endfunction

   task automatic model();
      longint e, v, sx, sy, W, H;
      longint px [6];
      longint py [6];
      longint a  [6];
      e  = longint'(1) << es;
      v  = (vw == 0) ? longint'(wd) : longint'(vw);
      sx = (xs == 0) ? 1 : longint'(xs);
      sy = (ys == 0) ? 1 : longint'(ys);
      W  = longint'(wd) - 1;
      H  = longint'(ht) - 1;
      case ({rot[1:0], mir})   // R7 table: top, bottom, elemA, elemB, frameA, frameB
         3'b000: begin px='{0,W,0,1,W,0}; py='{0,H,0,0,0,1}; end
         3'b001: begin px='{W,0,1,0,0,W}; py='{0,H,0,0,0,1}; end
         3'b010: begin px='{0,W,0,0,0,1}; py='{H,0,1,0,0,H}; end
         3'b011: begin px='{W,0,0,0,1,0}; py='{H,0,1,0,0,H}; end
         3'b100: begin px='{W,0,1,0,0,W}; py='{H,0,0,0,1,0}; end
         3'b101: begin px='{0,W,0,1,W,0}; py='{H,0,0,0,1,0}; end
         3'b110: begin px='{W,0,0,0,1,0}; py='{0,H,0,1,H,0}; end
         default: begin px='{0,W,0,0,0,1}; py='{0,H,0,1,H,0}; end
      endcase
      for (int i = 0; i < 6; i++)
         a[i] = longint'(base) + (py[i] * v * sy + px[i] * sx) * e;
      x_top = a[0][31:0];
      x_bot = a[1][31:0];
      x_ei  = 32'(a[3] - a[2] - e + 1);
      x_fi  = 32'(a[5] - a[4] - e + 1);
      x_en  = rot[0] ? ht : wd;
      x_fn  = rot[0] ? wd : ht;
   endtask

   task automatic check_outputs(input string tag);
      chk(top == x_top, "R3", {tag, " top"}, top, x_top);
      chk(bot == x_bot, "R3", {tag, " bottom"}, bot, x_bot);
      chk(ei == x_ei, "R6", {tag, " elem index"}, ei, x_ei);
      chk(fi == x_fi, "R6", {tag, " frame index"}, fi, x_fi);
      chk(en == x_en, "R5", {tag, " elem count"}, en, x_en);
      chk(fn == x_fn, "R5", {tag, " frame count"}, fn, x_fn);
   endtask

   // run one start; poke = issue a second start with other settings while busy (R9)
   task automatic run(input bit poke, input string tag);
      logic [31:0] p_top, p_bot, p_ei, p_fi;
      logic [11:0] p_en, p_fn;
      bit bad;
      @(negedge clk);
      p_top = top; p_bot = bot; p_ei = ei; p_fi = fi; p_en = en; p_fn = fn;
      bad = cfg_is_bad();
      if (!bad) model();
      start = 1'b1;
      @(negedge clk);                       // one edge after start
      start = 1'b0;
      if (bad) begin
         chk(done && err, "R4", {tag, " rejected start done+err"}, {done, err}, 2'b11);
         @(negedge clk);
         chk(!done && err, "R8", {tag, " err held, done dropped"}, {done, err}, 2'b01);
         chk(top == p_top && bot == p_bot && ei == p_ei && fi == p_fi &&
             en == p_en && fn == p_fn, "R10", {tag, " outputs kept on error"}, top, p_top);
         return;
      end
      chk(!done, "R8", {tag, " no early done"}, done, 0);
      if (poke) begin
         @(negedge clk);
         wd = wd ^ 12'h5; ht = ht + 12'd3; rot = rot ^ 3'd1; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         repeat (4) @(negedge clk);
      end else begin
         repeat (6) @(negedge clk);
      end
      chk(!done, "R8", {tag, " done low one cycle before due"}, done, 0);
      @(negedge clk);                       // seventh edge after start
      chk(done && !err, "R8", {tag, " done at edge 7"}, {done, err}, 2'b10);
      check_outputs(poke ? {tag, " R9 busy start ignored"} : tag);
      @(negedge clk);
      chk(!done, "R8", {tag, " done single cycle"}, done, 0);
   endtask

   task automatic rand_cfg(input bit allow_bad);
      base = $urandom;
      wd   = 12'($urandom_range(1, 400));
      ht   = 12'($urandom_range(1, 400));
      vw   = ($urandom_range(0, 2) == 0) ? 12'd0 : wd + 12'($urandom_range(0, 60));
      xs   = 4'($urandom_range(0, 15));
      ys   = 4'($urandom_range(0, 15));
      es   = 2'($urandom_range(0, 2));
      rot  = 3'($urandom_range(0, 3));
      mir  = 1'($urandom_range(0, 1));
      if (allow_bad && $urandom_range(0, 5) == 0) begin
         case ($urandom_range(0, 3))
            0: es = 2'd3;
            1: rot = 3'($urandom_range(4, 7));
            2: wd = 12'd0;
            default: begin wd = 12'd50; vw = 12'd20; end
         endcase
      end
   endtask

   initial begin
      #(CLK_P * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(!done && !err, "R1", "reset flags", {done, err}, 0);
      chk(top == 0 && bot == 0 && ei == 0 && fi == 0 && en == 0 && fn == 0,
          "R1", "reset outputs", top | bot | ei | fi, 0);
      rst_n = 1'b1;

      // directed: all rotations and mirrors on one geometry (R5, R7)
      base = 32'h1000_0000; wd = 12'd8; ht = 12'd5; vw = 12'd10; xs = 4'd1; ys = 4'd1; es = 2'd1;
      for (int r = 0; r < 4; r++) begin
         for (int m = 0; m < 2; m++) begin
            rot = 3'(r); mir = 1'(m);
            run(1'b0, $sformatf("R7 rot%0d mir%0d", r, m));
         end
      end
      // R2: each element size, zero defaults (R3)
      for (int s = 0; s < 3; s++) begin
         es = 2'(s); vw = 12'd0; xs = 4'd0; ys = 4'd0; rot = 3'd0; mir = 1'b0;
         run(1'b0, $sformatf("R2 esize code %0d", s));
      end
      // R3: 1x1 image, and the widest geometry with address wrap
      wd = 12'd1; ht = 12'd1; vw = 12'd0; es = 2'd2; rot = 3'd3; mir = 1'b1;
      run(1'b0, "R3 single pixel");
      base = 32'hFFFF_FF00; wd = 12'd4095; ht = 12'd4095; vw = 12'd4095;
      xs = 4'd15; ys = 4'd15; es = 2'd2; rot = 3'd1; mir = 1'b0;
      run(1'b0, "R3 max geometry wrap");
      // R10: input changes without start leave outputs alone
      wd = 12'd7; ht = 12'd9; rot = 3'd2; base = 32'h0;
      repeat (5) @(negedge clk);
      chk(top == x_top && ei == x_ei && en == x_en, "R10", "hold without start", top, x_top);
      // R2 / R5 / R4 rejected settings
      base = 32'h40; wd = 12'd16; ht = 12'd16; vw = 12'd0; xs = 4'd1; ys = 4'd1; rot = 3'd0;
      es = 2'd3; run(1'b0, "R2 esize code 3");
      es = 2'd0; rot = 3'd5; run(1'b0, "R5 rotation code 5");
      rot = 3'd0; ht = 12'd0; run(1'b0, "R4 zero height");
      ht = 12'd16; vw = 12'd15; run(1'b0, "R4 vwidth below width");
      vw = 12'd16; run(1'b0, "R4 vwidth equal width ok");
      // R9: start while busy
      rot = 3'd2; mir = 1'b1; run(1'b1, "R9");
      // random mix
      for (int t = 0; t < 120; t++) begin
         rand_cfg(1'b1);
         run(t % 9 == 4, $sformatf("rand %0d", t));
      end
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule